// File: doc/BRIEF.md
# Sprite Attribute Memory Access Controller

This block holds the 160-byte table of sprite attributes for a tile-based display engine and arbitrates processor accesses to it against the display timing. An external timing unit supplies the display-enable flag, the current display phase and the dot position within the line. When the display is off, or during the horizontal or vertical blanking phases, the processor reads and writes bytes freely. During pixel transfer the table is locked: reads return 0xFF and writes are dropped. During the attribute-scan phase, an access is not simply locked out. It disturbs the 8-byte row that the scanner is visiting, and rewrites that row from bitwise blends of its neighbours.

The table is 20 rows of 8 bytes. Each row holds four 16-bit words, stored low byte first. A corrupting access starts a short sequence that writes one word per cycle. The processor port reports busy until the sequence ends. A separate request flag selects the read-plus-increment flavour of corruption. A second, read-only port lets the sprite fetcher read any byte, with one cycle of latency, whatever the display phase.

Top module: `sprite_attr_ctrl`

## Requirements
- R1: Byte address A (0 to 159) selects row A/8, word (A/2)%4, and the low byte when A is even. An access with `lcd_on`=0, or with `lcd_mode` 0 (horizontal blank) or 1 (vertical blank), reads or writes that byte. A read returns the stored byte.
- R2: With `lcd_on`=1 and `lcd_mode`=3 (pixel transfer), a read returns 0xFF and a write is dropped. The same holds for `lcd_mode`=2 when `dot` is 80 or more. In both cases nothing in the table changes.
- R3: With `lcd_on`=1, `lcd_mode`=2 and row n = `dot`/4 in 1..19, a write discards its data. Word 0 of row n becomes ((a^c)&(b^c))^c, where a is word 0 of row n, b is word 0 of row n-1 and c is word 2 of row n-1. Words 1 to 3 of row n are copied from row n-1, and row n-1 is left unchanged.
- R4: Under the same scan-phase condition, a read with `cpu_idu`=0 returns 0xFF and word 0 of row n becomes b|(a&c), with the same operands as R3. Words 1 to 3 are copied from row n-1.
- R5: During the scan phase with `dot` 0 to 3 (row 0), a read returns 0xFF, a write is dropped and no row changes. The response arrives on the next cycle with no busy period.
- R6: A scan-phase read with `cpu_idu`=1 on row n in 4..18 works in three steps. First, word 0 of row n-1 becomes (b&(a|c|d))|(a&c&d), where a is word 0 of row n-2, b is word 0 of row n-1, c is word 0 of row n and d is word 2 of row n-1. Then the updated row n-1 is copied into rows n-2 and n. Finally, R4 corruption is applied to row n. `cpu_idu` has no effect on writes.
- R7: A scan-phase read with `cpu_idu`=1 on rows 1 to 3 or row 19 behaves exactly as R4.
- R8: A request is accepted only while `cpu_busy`=0, and requests made while busy are ignored. An access that does not corrupt pulses `cpu_done` for one cycle, in the cycle after acceptance. A corrupting access raises `cpu_busy` for 4 cycles (R3, R4, R7) or 9 cycles (R6), with `cpu_done` low. `cpu_done` then pulses in the cycle in which `cpu_busy` falls.
- R9: Addresses 160 and above read 0xFF, drop writes and never trigger corruption.
- R10: `fetch_data` shows, one cycle after `fetch_addr` is sampled, the stored byte at that address, in every display phase. It shows 0xFF for addresses of 160 and above.
- R11: After reset the whole table reads zero, `cpu_busy` and `cpu_done` are 0, and `cpu_rdata` and `fetch_data` are 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lcd_on | input | 1 | Display enable from the timing unit |
| lcd_mode | input | 2 | Display phase: 0 hblank, 1 vblank, 2 attribute scan, 3 pixel transfer |
| dot | input | 9 | Dot position within the current line |
| cpu_req | input | 1 | Processor access request, one cycle |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_idu | input | 1 | Selects read-plus-increment corruption on reads |
| cpu_addr | input | 8 | Byte offset into the table |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid with cpu_done after a read |
| cpu_done | output | 1 | Access completion pulse |
| cpu_busy | output | 1 | Corruption sequence in progress |
| fetch_addr | input | 8 | Sprite fetcher byte address |
| fetch_data | output | 8 | Sprite fetcher read data, one cycle latency |

## Verification
Directed accesses are made in each display phase against a table filled with a distinct byte per address. A change in read data, or in later fetch-port contents, therefore separates open, locked and corrupting behaviour. Scan-phase accesses are placed on rows 0, 1, 2, 3, 4, 5, 18 and 19, so that the immune row, the boundaries of the three-row variant and the plain blends each give different table images. A long stretch of randomised phases, dot positions, addresses and data follows, mixed with requests issued while busy. The fetch port sweeps every address on every cycle, so any stray or missing word write in a sequence is seen as a byte mismatch.

// File: rtl/sprattr_pkg.sv
// Shared types for the sprite attribute memory controller.
package sprattr_pkg;

    // Display phase as reported by the external timing unit.
    typedef enum logic [1:0] {
        MODE_HBLANK = 2'd0,
        MODE_VBLANK = 2'd1,
        MODE_SCAN   = 2'd2,
        MODE_XFER   = 2'd3
    } lcd_mode_e;

    // Kind of row-disturbing sequence to run.
    typedef enum logic [1:0] {
        SEQ_WRITE    = 2'd0,
        SEQ_READ     = 2'd1,
        SEQ_READ_INC = 2'd2
    } seq_kind_e;

    // One table row: four 16-bit words, word 0 at index 0.
    typedef logic [3:0][15:0] row_t;

endpackage

// File: rtl/sprattr_store.sv
// Word-organised attribute table with one word write port with byte
// enables, a combinational three-row view around a selected row, a
// combinational processor byte read and a registered fetcher byte read.
// Assumes row_sel is always below ROWS (the caller clamps it).
module sprattr_store
    import sprattr_pkg::*;
#(
    parameter int ROWS   = 20,
    parameter int ADDR_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [$clog2(ROWS*4)-1:0]    wr_idx,
    input  logic [1:0]                   wr_be,
    input  logic [15:0]                  wr_data,
    input  logic [$clog2(ROWS)-1:0]      row_sel,
    output row_t                         cur_row,
    output row_t                         prev_row,
    output row_t                         prev2_row,
    input  logic [ADDR_W-1:0]            cpu_addr,
    output logic [7:0]                   cpu_byte,
    input  logic [ADDR_W-1:0]            fetch_addr,
    output logic [7:0]                   fetch_data
);
    localparam int NWORDS = ROWS * 4;
    localparam int NBYTES = ROWS * 8;
    localparam int WIW    = $clog2(NWORDS);
    localparam int RW     = $clog2(ROWS);

    logic [15:0] mem [NWORDS];
    logic [RW-1:0] prev_sel, prev2_sel;

    // One register per word, written when its index is addressed.
    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (wr_en && wr_idx == WIW'(g)) begin
                if (wr_be[0]) mem[g][7:0]  <= wr_data[7:0];
                if (wr_be[1]) mem[g][15:8] <= wr_data[15:8];
            end
        end
    end

    // Neighbour row indices, held at zero below the table start.
    always_comb begin
        prev_sel  = (row_sel == '0) ? '0 : row_sel - RW'(1);
        prev2_sel = (row_sel < RW'(2)) ? '0 : row_sel - RW'(2);
    end

    // Three-row view for the corruption sequencer.
    for (genvar k = 0; k < 4; k++) begin : g_view
        assign cur_row[k]   = mem[{row_sel,   2'(k)}];
        assign prev_row[k]  = mem[{prev_sel,  2'(k)}];
        assign prev2_row[k] = mem[{prev2_sel, 2'(k)}];
    end

    function automatic logic [7:0] pick_byte(input logic [ADDR_W-1:0] a);
        logic [15:0] w;
        if (a >= ADDR_W'(NBYTES)) return 8'hFF;
        w = mem[WIW'(a >> 1)];
        return a[0] ? w[15:8] : w[7:0];
    endfunction

    // Processor byte read, decoded without a register.
    assign cpu_byte = pick_byte(cpu_addr);

    // Fetcher byte read, registered.
    always_ff @(posedge clk) begin
        if (!rst_n) fetch_data <= 8'hFF;
        else        fetch_data <= pick_byte(fetch_addr);
    end

endmodule

// File: rtl/sprattr_seq.sv
// Corruption sequencer. On start it computes the new word 0 and latches
// it, together with words 1..3 of the previous row and the target row,
// before any word is written. It then writes one word per cycle: 4
// writes for the plain blends, 9 for the read-plus-increment variant.
// Assumes SEQ_READ_INC is only requested for rows 4..ROWS-2.
module sprattr_seq
    import sprattr_pkg::*;
#(
    parameter int ROWS = 20
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  seq_kind_e                    kind,
    input  logic [$clog2(ROWS)-1:0]      row,
    input  row_t                         cur_row,
    input  row_t                         prev_row,
    input  row_t                         prev2_row,
    output logic                         busy,
    output logic                         finish,
    output logic                         wr_en,
    output logic [$clog2(ROWS*4)-1:0]    wr_idx,
    output logic [15:0]                  wr_data
);
    localparam int RW = $clog2(ROWS);
    localparam logic [3:0] LAST_PLAIN = 4'd3;
    localparam logic [3:0] LAST_INC   = 4'd8;

    logic            active;
    logic [3:0]      step;
    logic [3:0]      last;
    logic [RW-1:0]   row_q;
    seq_kind_e       kind_q;
    row_t            vals;
    logic [15:0]     w0_new;
    logic [RW-1:0]   tgt_row;
    logic [1:0]      tgt_word;

    // New word 0 from the operands present at the start cycle.
    always_comb begin
        logic [15:0] a, b, c, a2;
        a  = cur_row[0];
        b  = prev_row[0];
        c  = prev_row[2];
        a2 = prev2_row[0];
        case (kind)
            SEQ_WRITE:    w0_new = ((a ^ c) & (b ^ c)) ^ c;
            SEQ_READ_INC: w0_new = (b & (a2 | a | c)) | (a2 & a & c);
            default:      w0_new = b | (a & c);
        endcase
    end

    assign last = (kind_q == SEQ_READ_INC) ? LAST_INC : LAST_PLAIN;

    // Latch operands on start, then step through the word writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            step   <= '0;
            row_q  <= '0;
            kind_q <= SEQ_WRITE;
            vals   <= '0;
        end else if (start) begin
            active <= 1'b1;
            step   <= '0;
            row_q  <= row;
            kind_q <= kind;
            vals   <= {prev_row[3], prev_row[2], prev_row[1], w0_new};
        end else if (active) begin
            step <= step + 4'd1;
            if (step == last) active <= 1'b0;
        end
    end

    // Target word of the current step.
    always_comb begin
        tgt_row  = row_q;
        tgt_word = step[1:0];
        if (kind_q == SEQ_READ_INC) begin
            if (step == 4'd0) begin
                tgt_row  = row_q - RW'(1);
                tgt_word = 2'd0;
            end else if (step <= 4'd4) begin
                tgt_row  = row_q - RW'(2);
                tgt_word = 2'(step - 4'd1);
            end else begin
                tgt_word = 2'(step - 4'd5);
            end
        end
    end

    assign wr_en   = active;
    assign wr_idx  = {tgt_row, tgt_word};
    assign wr_data = vals[tgt_word];
    assign busy    = active;
    assign finish  = active && (step == last);

    // R8: the step counter never runs past the final write.
    p_step_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> step <= last);

    // R6: the three-row variant only runs on rows that have two rows above
    // and one row below them.
    p_inc_rows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && kind_q == SEQ_READ_INC) |-> (row_q >= RW'(4) && row_q <= RW'(ROWS - 2)));

endmodule

// File: rtl/sprite_attr_ctrl.sv
// Sprite attribute memory access controller. Decodes each processor
// request against the display phase and dot position into one of three
// outcomes: open access, locked (0xFF / dropped) or row corruption. It
// owns the processor response registers and arbitrates the single table
// write port between open writes and the corruption sequencer.
// Assumes the timing inputs are synchronous to clk.
module sprite_attr_ctrl
    import sprattr_pkg::*;
#(
    parameter int ROWS   = 20,
    parameter int ADDR_W = 8,
    parameter int DOT_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lcd_on,
    input  logic [1:0]        lcd_mode,
    input  logic [DOT_W-1:0]  dot,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_idu,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    output logic              cpu_done,
    output logic              cpu_busy,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [7:0]        fetch_data
);
    localparam int NBYTES    = ROWS * 8;
    localparam int SCAN_DOTS = ROWS * 4;
    localparam int RW        = $clog2(ROWS);
    localparam int WIW       = $clog2(ROWS * 4);

    lcd_mode_e       mode;
    logic            accept, in_range, row_ok, cpu_open, scan_hit, seq_start;
    logic            inc_ok, plain_wr;
    logic [RW-1:0]   scan_row;
    seq_kind_e       kind;
    row_t            cur_row, prev_row, prev2_row;
    logic [7:0]      cpu_byte;
    logic            seq_busy, seq_finish, seq_wr_en;
    logic [WIW-1:0]  seq_wr_idx, st_wr_idx;
    logic [15:0]     seq_wr_data, st_wr_data;
    logic [1:0]      st_wr_be;
    logic            st_wr_en;

    // Request decode against the display phase.
    always_comb begin
        mode      = lcd_mode_e'(lcd_mode);
        accept    = cpu_req && !seq_busy;
        in_range  = cpu_addr < ADDR_W'(NBYTES);
        row_ok    = dot < DOT_W'(SCAN_DOTS);
        scan_row  = row_ok ? RW'(dot >> 2) : '0;
        cpu_open  = !lcd_on || mode == MODE_HBLANK || mode == MODE_VBLANK;
        scan_hit  = lcd_on && mode == MODE_SCAN && row_ok && scan_row != '0;
        seq_start = accept && in_range && scan_hit;
        inc_ok    = scan_row >= RW'(4) && scan_row <= RW'(ROWS - 2);
        kind      = cpu_we ? SEQ_WRITE : ((cpu_idu && inc_ok) ? SEQ_READ_INC : SEQ_READ);
        plain_wr  = accept && in_range && cpu_open && cpu_we;
    end

    // Single write port: the sequencer wins; open writes only occur when idle.
    always_comb begin
        st_wr_en   = seq_wr_en || plain_wr;
        st_wr_idx  = seq_wr_en ? seq_wr_idx : WIW'(cpu_addr >> 1);
        st_wr_data = seq_wr_en ? seq_wr_data : {cpu_wdata, cpu_wdata};
        st_wr_be   = seq_wr_en ? 2'b11 : (cpu_addr[0] ? 2'b10 : 2'b01);
    end

    sprattr_store #(.ROWS(ROWS), .ADDR_W(ADDR_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (st_wr_en),
        .wr_idx     (st_wr_idx),
        .wr_be      (st_wr_be),
        .wr_data    (st_wr_data),
        .row_sel    (scan_row),
        .cur_row    (cur_row),
        .prev_row   (prev_row),
        .prev2_row  (prev2_row),
        .cpu_addr   (cpu_addr),
        .cpu_byte   (cpu_byte),
        .fetch_addr (fetch_addr),
        .fetch_data (fetch_data)
    );

    sprattr_seq #(.ROWS(ROWS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (seq_start),
        .kind      (kind),
        .row       (scan_row),
        .cur_row   (cur_row),
        .prev_row  (prev_row),
        .prev2_row (prev2_row),
        .busy      (seq_busy),
        .finish    (seq_finish),
        .wr_en     (seq_wr_en),
        .wr_idx    (seq_wr_idx),
        .wr_data   (seq_wr_data)
    );

    // Processor response: read data and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rdata <= 8'hFF;
            cpu_done  <= 1'b0;
        end else begin
            cpu_done <= (accept && !seq_start) || seq_finish;
            if (accept && !cpu_we)
                cpu_rdata <= (in_range && cpu_open) ? cpu_byte : 8'hFF;
        end
    end

    assign cpu_busy = seq_busy;

    // R2: a pixel-transfer read completes next cycle with 0xFF.
    p_xfer_read_ff_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_busy && !cpu_we && lcd_on && lcd_mode == 2'd3)
        |=> (cpu_done && cpu_rdata == 8'hFF));

    // R9: an out-of-range read completes next cycle with 0xFF.
    p_oob_read_ff_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_busy && !cpu_we && cpu_addr >= ADDR_W'(NBYTES))
        |=> (cpu_done && cpu_rdata == 8'hFF && !cpu_busy));

    // R5: an access during the row-0 scan window never starts a sequence.
    p_row0_quick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_busy && lcd_on && lcd_mode == 2'd2 && dot < DOT_W'(4))
        |=> (cpu_done && !cpu_busy));

    // R8: an in-range access on rows 1.. of the scan window turns busy without completing.
    p_scan_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_busy && cpu_addr < ADDR_W'(NBYTES) && lcd_on && lcd_mode == 2'd2
         && dot >= DOT_W'(4) && dot < DOT_W'(SCAN_DOTS))
        |=> (cpu_busy && !cpu_done));

    // R8: completion and busy are never seen together.
    p_done_not_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> !cpu_busy);

endmodule

// File: tb/sprite_attr_ctrl_bench.sv
module sprite_attr_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       lcd_on;
    logic [1:0] lcd_mode;
    logic [8:0] dot;
    logic       cpu_req, cpu_we, cpu_idu;
    logic [7:0] cpu_addr, cpu_wdata;
    logic [7:0] cpu_rdata;
    logic       cpu_done, cpu_busy;
    logic [7:0] fetch_addr;
    logic [7:0] fetch_data;

    always #10 clk = ~clk;

    sprite_attr_ctrl u_sprite_attr_ctrl (
        .clk(clk), .rst_n(rst_n), .lcd_on(lcd_on), .lcd_mode(lcd_mode), .dot(dot),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_idu(cpu_idu), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
        .cpu_busy(cpu_busy), .fetch_addr(fetch_addr), .fetch_data(fetch_data)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit running = 0;

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int    mm [160];
    bit    m_busy, m_done, m_rd, m_fetch_ok;
    int    m_rdata, m_fetch, m_rem;
    string m_tag = "R1";

    function automatic int wget(int r, int w);
        return mm[r*8 + w*2] | (mm[r*8 + w*2 + 1] << 8);
    endfunction

    function automatic void wset(int r, int w, int v);
        mm[r*8 + w*2]     = v & 255;
        mm[r*8 + w*2 + 1] = (v >> 8) & 255;
    endfunction

    function automatic void read_blend(int n);
        int a, b, c;
        a = wget(n, 0); b = wget(n-1, 0); c = wget(n-1, 2);
        wset(n, 0, b | (a & c));
        for (int k = 1; k < 4; k++) wset(n, k, wget(n-1, k));
    endfunction

    function automatic void write_blend(int n);
        int a, b, c;
        a = wget(n, 0); b = wget(n-1, 0); c = wget(n-1, 2);
        wset(n, 0, (((a ^ c) & (b ^ c)) ^ c) & 16'hFFFF);
        for (int k = 1; k < 4; k++) wset(n, k, wget(n-1, k));
    endfunction

    function automatic void inc_blend(int n);
        int a, b, c, d;
        a = wget(n-2, 0); b = wget(n-1, 0); c = wget(n, 0); d = wget(n-1, 2);
        wset(n-1, 0, (b & (a | c | d)) | (a & c & d));
        for (int k = 0; k < 4; k++) begin
            wset(n-2, k, wget(n-1, k));
            wset(n, k, wget(n-1, k));
        end
        read_blend(n);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 160; i++) mm[i] = 0;
            m_busy = 0; m_done = 0; m_rd = 0; m_rem = 0;
            m_rdata = 8'hFF; m_fetch = 8'hFF; m_fetch_ok = 1;
        end else begin
            int a, row;
            m_fetch_ok = !m_busy;
            m_fetch    = (fetch_addr < 160) ? mm[fetch_addr] : 8'hFF;
            if (m_busy) begin
                m_rem--;
                if (m_rem == 0) begin m_busy = 0; m_done = 1; end
                else m_done = 0;
            end else begin
                m_done = 0;
                if (cpu_req) begin
                    a   = cpu_addr;
                    row = dot / 4;
                    m_rd = !cpu_we;
                    if (a >= 160) begin
                        m_done = 1; m_tag = "R9";
                        if (!cpu_we) m_rdata = 8'hFF;
                    end else if (!lcd_on || lcd_mode < 2) begin
                        m_done = 1; m_tag = "R1";
                        if (cpu_we) mm[a] = cpu_wdata;
                        else m_rdata = mm[a];
                    end else if (lcd_mode == 3 || row >= 20) begin
                        m_done = 1; m_tag = "R2";
                        if (!cpu_we) m_rdata = 8'hFF;
                    end else if (row == 0) begin
                        m_done = 1; m_tag = "R5";
                        if (!cpu_we) m_rdata = 8'hFF;
                    end else begin
                        m_busy = 1; m_rem = 4;
                        if (cpu_we) begin
                            m_tag = "R3"; write_blend(row);
                        end else begin
                            m_rdata = 8'hFF;
                            if (cpu_idu && row >= 4 && row <= 18) begin
                                m_tag = "R6"; m_rem = 9; inc_blend(row);
                            end else begin
                                m_tag = cpu_idu ? "R7" : "R4"; read_blend(row);
                            end
                        end
                    end
                end
            end
        end
    end

    // Per-cycle comparison, away from the clock edge.
    always @(posedge clk) begin
        #5;
        if (rst_n && running) begin
            chk(cpu_busy == m_busy, "R8 busy", cpu_busy, m_busy);
            chk(cpu_done == m_done, "R8 done", cpu_done, m_done);
            if (m_done && m_rd) chk(cpu_rdata == m_rdata, m_tag, cpu_rdata, m_rdata);
            if (m_fetch_ok) chk(fetch_data == m_fetch, "R10 fetch", fetch_data, m_fetch);
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        fetch_addr = 8'd0;
        forever begin
            @(negedge clk);
            fetch_addr = (fetch_addr == 8'd171) ? 8'd0 : fetch_addr + 8'd1;
        end
    end

    task automatic op(bit on, int md, int d, bit we, bit idu, int addr, int data);
        @(negedge clk);
        while (cpu_busy) @(negedge clk);
        lcd_on = on; lcd_mode = 2'(md); dot = 9'(d);
        cpu_we = we; cpu_idu = idu; cpu_addr = 8'(addr); cpu_wdata = 8'(data);
        cpu_req = 1'b1;
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic fill(int seed);
        for (int i = 0; i < 160; i++) op(0, 0, 0, 1, 0, i, (i * 37 + seed) & 255);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (cpu_busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        rst_n = 0; lcd_on = 0; lcd_mode = 0; dot = 0;
        cpu_req = 0; cpu_we = 0; cpu_idu = 0; cpu_addr = 0; cpu_wdata = 0;
        repeat (4) @(negedge clk);
        // R11 reset state
        chk(cpu_busy == 0, "R11 busy", cpu_busy, 0);
        chk(cpu_done == 0, "R11 done", cpu_done, 0);
        chk(cpu_rdata == 8'hFF, "R11 rdata", cpu_rdata, 8'hFF);
        chk(fetch_data == 8'hFF, "R11 fetch", fetch_data, 8'hFF);
        rst_n = 1; running = 1;
        op(0, 0, 0, 0, 0, 9, 0);
        chk(cpu_rdata == 8'h00, "R11 table cleared", cpu_rdata, 0);

        fill(11);
        // R1: open phases
        op(1, 0, 300, 0, 0, 17, 0);
        op(1, 1, 10, 0, 0, 158, 0);
        op(1, 0, 200, 1, 0, 40, 8'hA5);
        op(0, 3, 0, 0, 0, 40, 0);
        // R2: pixel transfer and late scan dots
        op(1, 3, 100, 1, 0, 12, 8'h3C);
        op(1, 3, 100, 0, 0, 12, 0);
        op(1, 2, 85, 1, 0, 13, 8'h99);
        op(0, 0, 0, 0, 0, 12, 0);
        op(0, 0, 0, 0, 0, 13, 0);
        // R3 and R4: rows 1, 2, 3
        op(1, 2, 9, 1, 0, 70, 8'h55);
        op(1, 2, 12, 0, 0, 3, 0);
        op(1, 2, 5, 0, 0, 100, 0);
        // R5: row 0
        op(1, 2, 2, 1, 0, 0, 8'h77);
        op(1, 2, 3, 0, 0, 1, 0);
        // R6: rows 4, 5, 18
        fill(91);
        op(1, 2, 20, 0, 1, 50, 0);
        op(1, 2, 16, 0, 1, 50, 0);
        op(1, 2, 73, 0, 1, 2, 0);
        op(1, 2, 24, 1, 1, 2, 8'h11);
        // R7: rows 1, 3, 19
        fill(203);
        op(1, 2, 4, 0, 1, 7, 0);
        op(1, 2, 14, 0, 1, 7, 0);
        op(1, 2, 79, 0, 1, 7, 0);
        // R9: out of range
        op(0, 0, 0, 1, 0, 160, 8'h12);
        op(0, 0, 0, 0, 0, 200, 0);
        op(1, 2, 30, 1, 0, 255, 8'h34);
        // R8: requests while busy are ignored
        op(1, 2, 40, 0, 1, 5, 0);
        lcd_on = 0; cpu_we = 1; cpu_addr = 8'd1; cpu_wdata = 8'hEE;
        for (int i = 0; i < 3; i++) begin
            cpu_req = 1; @(negedge clk); cpu_req = 0;
        end
        wait_idle();
        op(0, 0, 0, 0, 0, 1, 0);
        repeat (200) @(negedge clk);

        // Randomised mix
        for (int i = 0; i < 600; i++) begin
            bit on;
            on = ($urandom_range(0, 4) != 0);
            if (!on) op(0, 0, 0, 1, 0, $urandom_range(0, 159), $urandom_range(0, 255));
            else op(1, $urandom_range(0, 3), $urandom_range(0, 90), $urandom_range(0, 2) == 0,
                    $urandom_range(0, 1), $urandom_range(0, 175), $urandom_range(0, 255));
            if ($urandom_range(0, 5) == 0) begin
                cpu_req = 1; @(negedge clk); cpu_req = 0;
            end
        end
        wait_idle();
        repeat (200) @(negedge clk);
        running = 0;
        summary();
    end
endmodule